// File: doc/BRIEF.md
# Pipelined Next-PC Tracker

This block moves a program-counter value alongside every instruction through a four-stage in-order pipeline. The stages are fetched, decoded, operand and ALU, and retirement follows the ALU stage. A fetched instruction enters the first stage with its own address. When it leaves decode, that address is replaced by the address of the following instruction: the address plus the length reported by the decoder. This next-PC then rides unchanged through the later stages and only reaches architectural state when the instruction retires. At that point it is written into the user PC or the supervisor PC, selected by a mode input.

Addresses are counted in 16-bit units, so a full-word instruction adds 2 and a half-word instruction adds 1. While an instruction sits in the operand-read stage, the block offers its carried next-PC plus an immediate as a ready-made B operand for the ALU. Each stage has a hold input. A held stage freezes itself and every older stage.

When a retiring instruction writes the PC, the ALU result becomes the new architectural PC and every stage is invalidated. The fetch address is also redirected to that value. This flush overrides any hold.

Top module: `pc_track`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four stage valid bits are 0, and the fetch address, the user PC and the supervisor PC equal the RESET_PC parameter.
- R2: A fetch is accepted when fetch_ack_i is 1, there is no flush and stage 0 is not blocked. On the next cycle stage 0 is valid with the old fetch address, and the fetch address has grown by FETCH_STEP.
- R3: Stage k is blocked when hold_i[j] is 1 for any j ≥ k. A blocked stage keeps its valid bit and PC. An unblocked stage takes the valid bit and PC of stage k-1 on the next edge; for stage 0, the source is the fetch.
- R4: On the move from stage 0 to stage 1, the PC becomes the stage-0 PC plus 1 if dec_half_i is 1, or plus 2 otherwise. The sum wraps modulo 2^PCW.
- R5: While stage 1 is valid, opnd_o equals the stage-1 PC plus imm_i, modulo 2^PCW, in the same cycle.
- R6: An instruction retires when stage 3 is valid and hold_i[3] is 0. If sup_i is 1, the supervisor PC is updated on the next cycle; otherwise the user PC is updated. The other PC is left unchanged. The value written is the stage-3 PC when wpc_i is 0.
- R7: flush_o is 1 exactly when an instruction retires with wpc_i set. That PC write stores alu_res_i into the selected PC instead of the carried value.
- R8: In the cycle after a flush, all four stage valid bits are 0 and the fetch address equals the alu_res_i given with the flush.
- R9: A flush clears stages that are held in the same cycle. No fetch is accepted in the flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_ack_i | input | 1 | Instruction at fetch_addr_o is delivered this cycle |
| dec_half_i | input | 1 | Instruction in stage 0 is a half-word (length 1) |
| hold_i | input | 4 | Per-stage hold, bit k for stage k |
| imm_i | input | PCW | Immediate added to the operand-stage PC |
| sup_i | input | 1 | Retiring instruction runs in supervisor mode |
| wpc_i | input | 1 | Retiring instruction writes the PC |
| alu_res_i | input | PCW | ALU result for the retiring instruction |
| fetch_addr_o | output | PCW | Current fetch request address |
| dec_pc_o | output | PCW | Address of the instruction in stage 0 |
| stage_vld_o | output | 4 | Valid bits of stages 0 to 3 |
| opnd_o | output | PCW | PC-relative B operand for the operand stage |
| alu_pc_o | output | PCW | Next-PC carried by stage 3 |
| flush_o | output | 1 | PC write at retire this cycle |
| upc_o | output | PCW | User architectural PC |
| spc_o | output | PCW | Supervisor architectural PC |

## Verification
The bench builds the block with PCW of 12, FETCH_STEP of 2 and RESET_PC of 12'hFF0. With these values the fetch address crosses the 12-bit boundary within a few accepted fetches. Decode sums and operand sums therefore wrap often, and a truncated carry stays visible. Random redirect targets and imm values cover the full 12-bit range. Mixed per-stage holds, together with occasional PC writes, bring held-during-flush cycles and alternating user and supervisor retirements within reach.

// File: rtl/pct_pkg.sv
package pct_pkg;
   localparam int PCT_NSTG = 4;

   typedef enum logic [1:0] {
      STG_FETCHED = 2'd0,
      STG_DECODED = 2'd1,
      STG_OPERAND = 2'd2,
      STG_ALU     = 2'd3
   } pct_stage_e;

   typedef enum logic {
      MODE_USER = 1'b0,
      MODE_SUP  = 1'b1
   } pct_mode_e;
endpackage

// File: rtl/pct_stage.sv
module pct_stage #(
   parameter int PCW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           blocked,
   input  logic           in_vld,
   input  logic [PCW-1:0] in_pc,
   output logic           vld,
   output logic [PCW-1:0] pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         pc  <= '0;
      end else if (flush) begin
         vld <= 1'b0;
      end else if (!blocked) begin
         vld <= in_vld;
         pc  <= in_pc;
      end
   end

   // R3
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && !flush) |=> ($stable(vld) && $stable(pc)));

   // R3
   move_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !flush && in_vld) |=> (vld && pc == $past(in_pc)));

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !vld);
endmodule

// File: rtl/pct_archpc.sv
module pct_archpc #(
   parameter int             PCW      = 32,
   parameter logic [PCW-1:0] RESET_PC = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           retire,
   input  pct_pkg::pct_mode_e mode,
   input  logic [PCW-1:0] value,
   output logic [PCW-1:0] upc,
   output logic [PCW-1:0] spc
);
   import pct_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upc <= RESET_PC;
         spc <= RESET_PC;
      end else if (retire) begin
         if (mode == MODE_SUP) spc <= value;
         else                  upc <= value;
      end
   end

   // R6
   sup_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && mode == MODE_SUP) |=> ($stable(upc) && spc == $past(value)));

   // R6
   user_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && mode == MODE_USER) |=> ($stable(spc) && upc == $past(value)));
endmodule

// File: rtl/pc_track.sv
module pc_track #(
   parameter int             PCW        = 32,
   parameter int             FETCH_STEP = 2,
   parameter logic [PCW-1:0] RESET_PC   = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fetch_ack_i,
   input  logic                        dec_half_i,
   input  logic [pct_pkg::PCT_NSTG-1:0] hold_i,
   input  logic [PCW-1:0]              imm_i,
   input  logic                        sup_i,
   input  logic                        wpc_i,
   input  logic [PCW-1:0]              alu_res_i,
   output logic [PCW-1:0]              fetch_addr_o,
   output logic [PCW-1:0]              dec_pc_o,
   output logic [pct_pkg::PCT_NSTG-1:0] stage_vld_o,
   output logic [PCW-1:0]              opnd_o,
   output logic [PCW-1:0]              alu_pc_o,
   output logic                        flush_o,
   output logic [PCW-1:0]              upc_o,
   output logic [PCW-1:0]              spc_o
);
   import pct_pkg::*;

   localparam int NS   = PCT_NSTG;
   localparam int LAST = NS - 1;

   initial begin
      assert (PCW >= 4) else $error("pc_track: PCW must be at least 4");
      assert (FETCH_STEP >= 1 && FETCH_STEP <= 2)
         else $error("pc_track: FETCH_STEP must be 1 or 2");
   end

   logic [NS-1:0]  blocked;
   logic [NS-1:0]  s_vld;
   logic [PCW-1:0] s_pc  [NS];
   logic [NS-1:0]  in_vld;
   logic [PCW-1:0] in_pc [NS];
   logic [PCW-1:0] fetch_addr;
   logic           retire;
   logic           flush;
   logic [PCW-1:0] ret_value;

   assign blocked[LAST] = hold_i[LAST];
   for (genvar k = 0; k < LAST; k++) begin : g_blk
      assign blocked[k] = hold_i[k] | blocked[k+1];
   end

   for (genvar k = 0; k < NS; k++) begin : g_stage
      if (k == int'(STG_FETCHED)) begin : g_src_fetch
         assign in_vld[k] = fetch_ack_i;
         assign in_pc[k]  = fetch_addr;
      end else if (k == int'(STG_DECODED)) begin : g_src_decode
         assign in_vld[k] = s_vld[k-1];
         assign in_pc[k]  = s_pc[k-1] + (dec_half_i ? PCW'(1) : PCW'(2));
      end else begin : g_src_pass
         assign in_vld[k] = s_vld[k-1];
         assign in_pc[k]  = s_pc[k-1];
      end

      pct_stage #(.PCW(PCW)) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .blocked (blocked[k]),
         .in_vld  (in_vld[k]),
         .in_pc   (in_pc[k]),
         .vld     (s_vld[k]),
         .pc      (s_pc[k])
      );
   end

   assign retire    = s_vld[LAST] & ~hold_i[LAST];
   assign flush     = retire & wpc_i;
   assign ret_value = wpc_i ? alu_res_i : s_pc[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               fetch_addr <= RESET_PC;
      else if (flush)                           fetch_addr <= alu_res_i;
      else if (fetch_ack_i && !blocked[0])      fetch_addr <= fetch_addr + PCW'(FETCH_STEP);
   end

   pct_archpc #(.PCW(PCW), .RESET_PC(RESET_PC)) u_arch (
      .clk    (clk),
      .rst_n  (rst_n),
      .retire (retire),
      .mode   (sup_i ? MODE_SUP : MODE_USER),
      .value  (ret_value),
      .upc    (upc_o),
      .spc    (spc_o)
   );

   assign fetch_addr_o = fetch_addr;
   assign dec_pc_o     = s_pc[int'(STG_FETCHED)];
   assign stage_vld_o  = s_vld;
   assign opnd_o       = s_pc[int'(STG_DECODED)] + imm_i;
   assign alu_pc_o     = s_pc[LAST];
   assign flush_o      = flush;

   // R2
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ack_i && !blocked[0] && !flush) |=>
         (fetch_addr_o == $past(fetch_addr_o) + PCW'(FETCH_STEP)));

   // R4
   decode_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld[0] && !blocked[1] && !flush) |=>
         (s_pc[1] == $past(s_pc[0]) + ($past(dec_half_i) ? PCW'(1) : PCW'(2))));

   // R8
   redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (fetch_addr_o == $past(alu_res_i) && stage_vld_o == '0));

   // R7
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (stage_vld_o[LAST] && wpc_i && !hold_i[LAST]));
endmodule

// File: tb/tb_pc_track.sv
`timescale 1ns/1ps
module tb_pc_track;
   localparam int         PCW  = 12;
   localparam int         STEP = 2;
   localparam logic [11:0] RST = 12'hFF0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch_ack_i = 0, dec_half_i = 0, sup_i = 0, wpc_i = 0;
   logic [3:0] hold_i = '0;
   logic [PCW-1:0] imm_i = '0, alu_res_i = '0;
   logic [PCW-1:0] fetch_addr_o, dec_pc_o, opnd_o, alu_pc_o, upc_o, spc_o;
   logic [3:0] stage_vld_o;
   logic flush_o;

   pc_track #(.PCW(PCW), .FETCH_STEP(STEP), .RESET_PC(RST)) dut (
      .clk(clk), .rst_n(rst_n), .fetch_ack_i(fetch_ack_i), .dec_half_i(dec_half_i),
      .hold_i(hold_i), .imm_i(imm_i), .sup_i(sup_i), .wpc_i(wpc_i),
      .alu_res_i(alu_res_i), .fetch_addr_o(fetch_addr_o), .dec_pc_o(dec_pc_o),
      .stage_vld_o(stage_vld_o), .opnd_o(opnd_o), .alu_pc_o(alu_pc_o),
      .flush_o(flush_o), .upc_o(upc_o), .spc_o(spc_o));

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [3:0]     mv;
   logic [PCW-1:0] mp [4];
   logic [PCW-1:0] maddr, mupc, mspc;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [PCW-1:0] len_of(input logic half);
      return half ? PCW'(1) : PCW'(2);
   endfunction

   task automatic check_state();
      chk("R3 stage valid", 32'(stage_vld_o), 32'(mv));
      chk("R2 fetch address", 32'(fetch_addr_o), 32'(maddr));
      chk("R6 user PC", 32'(upc_o), 32'(mupc));
      chk("R6 supervisor PC", 32'(spc_o), 32'(mspc));
      if (mv[0]) chk("R2 stage0 PC", 32'(dec_pc_o), 32'(mp[0]));
      if (mv[3]) chk("R4 alu stage PC", 32'(alu_pc_o), 32'(mp[3]));
   endtask

   task automatic step(input logic ack, input logic half, input logic [3:0] hold,
                       input logic [PCW-1:0] imm, input logic sup, input logic wpc,
                       input logic [PCW-1:0] res);
      logic [3:0] blk;
      logic ret, fl;
      logic [3:0] nv;
      logic [PCW-1:0] np [4];
      check_state();
      fetch_ack_i = ack; dec_half_i = half; hold_i = hold; imm_i = imm;
      sup_i = sup; wpc_i = wpc; alu_res_i = res;
      #1;
      blk[3] = hold[3];
      for (int k = 2; k >= 0; k--) blk[k] = hold[k] | blk[k+1];
      ret = mv[3] & ~hold[3];
      fl  = ret & wpc;
      chk("R7 flush output", 32'(flush_o), 32'(fl));
      if (mv[1]) chk("R5 operand", 32'(opnd_o), 32'(PCW'(mp[1] + imm)));
      for (int k = 0; k < 4; k++) begin nv[k] = mv[k]; np[k] = mp[k]; end
      if (fl) nv = '0;
      else begin
         if (!blk[0]) begin nv[0] = ack;   np[0] = maddr; end
         if (!blk[1]) begin nv[1] = mv[0]; np[1] = mp[0] + len_of(half); end
         if (!blk[2]) begin nv[2] = mv[1]; np[2] = mp[1]; end
         if (!blk[3]) begin nv[3] = mv[2]; np[3] = mp[2]; end
      end
      if (ret) begin
         if (sup) mspc = wpc ? res : mp[3];
         else     mupc = wpc ? res : mp[3];
      end
      if (fl) maddr = res;
      else if (ack && !blk[0]) maddr = maddr + PCW'(STEP);
      mv = nv;
      for (int k = 0; k < 4; k++) mp[k] = np[k];
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      mv = '0; maddr = RST; mupc = RST; mspc = RST;
      for (int k = 0; k < 4; k++) mp[k] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1 reset valid", 32'(stage_vld_o), 32'd0);
      chk("R1 reset fetch", 32'(fetch_addr_o), 32'(RST));
      chk("R1 reset upc", 32'(upc_o), 32'(RST));
      chk("R1 reset spc", 32'(spc_o), 32'(RST));
      rst_n = 1'b1;
      @(negedge clk);
      // Directed: fill with mixed lengths, wrap across 12'hFFF
      step(1, 0, 4'b0000, 12'h005, 0, 0, 0);
      step(1, 1, 4'b0000, 12'h010, 0, 0, 0);
      step(1, 0, 4'b0000, 12'hFFF, 0, 0, 0);
      step(1, 1, 4'b0000, 12'h001, 1, 0, 0);
      step(1, 0, 4'b0000, 12'h002, 0, 0, 0);
      // Stall stage 2 and older, then R9: flush while stages 0..2 are held
      step(1, 0, 4'b0100, 12'h003, 0, 0, 0);
      step(1, 0, 4'b0111, 12'h004, 1, 1, 12'h7A5);
      // R8: directly after the flush
      chk("R8 valids cleared", 32'(stage_vld_o), 32'd0);
      chk("R8 redirect", 32'(fetch_addr_o), 32'h7A5);
      chk("R7 supervisor gets result", 32'(spc_o), 32'h7A5);
      // Random phase
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] h;
         h = '0;
         for (int b = 0; b < 4; b++) h[b] = ($urandom_range(0, 5) == 0);
         step($urandom_range(0, 3) != 0, 1'($urandom), h, PCW'($urandom),
              1'($urandom), ($urandom_range(0, 11) == 0), PCW'($urandom));
      end
      check_state();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule